// File: doc/BRIEF.md
# Autoscan Averaging Sequencer

This block sits behind the decimation filter of a sigma-delta converter. It takes finished conversion words through a valid/ready input and steps through up to five input-multiplexer channels. Each channel has its own 16-bit setting word. The word holds an enable, a conversion count, an averaging switch, the averaging depth, the interrupt timing for averaging, and a result inversion used on single-ended inputs. Only enabled channels take part in a scan. The block counts the conversions taken on the active channel and then moves on to the next enabled channel. It ends after one pass, or it wraps around and keeps scanning, depending on the scan-mode input.

Every accepted word goes to a raw-result register. When averaging is on, the word is also added into an accumulator, and an average register is published once the chosen number of samples has been summed. Both registers carry a 3-bit channel tag and an overflow flag. Tag 0 means no valid value has been stored yet. A one-cycle interrupt pulse reports new data. A run starts in one of two ways, selected by a mode input: a rising edge of the start bit, or an event trigger while the start bit is held high. Dropping the start bit ends the run.

Top module: `scan_avg_seq`

Setting word per channel (channel k occupies `ch_cfg_i[16k+15:16k]`): bit 0 enable; bit 1 averaging on; bit 2 interrupt on every conversion while averaging; bits 4:3 depth code; bit 5 single-ended input; bit 6 invert request; bit 7 linear count mode; bits 15:8 count field.

## Requirements
- R1: After reset, busy, ready and the interrupt are low, and both channel tags read 0 (the invalid code).
- R2: A stored raw result carries tag k+1, where k is the multiplexer index (0 to 4) that was active when the word was accepted.
- R3: With averaging off (bit 1 = 0), every accepted word is written to the raw register with its tag, the interrupt pulses one cycle after each acceptance, and the average register is left untouched.
- R4: With averaging on, depth code d (bits 4:3 = 0,1,2,3) selects 8, 16, 32 or 64 samples. After that many samples, the average register holds the 31-bit signed sum shifted arithmetically right by 3+d (low 24 bits) and is tagged with the channel.
- R5: With averaging on, bit 2 = 1 gives an interrupt on every conversion, and bit 2 = 0 gives an interrupt only in the cycle after an average is published.
- R6: With bit 7 = 1 the channel count N equals the count field, and a field of 0 counts as 1. With bit 7 = 0, N = (m+1) shifted left by n, where m is field bits 4:0 and n is field bits 7:5, and N is capped at 8032.
- R7: Channels whose enable bit is clear are skipped. A start request while no channel is enabled leaves the block idle.
- R8: When scan mode is 0, the run ends after the last enabled channel has taken its N words. When scan mode is 1, the scan wraps to the lowest enabled channel and continues.
- R9: When trigger mode is 0, a 0-to-1 change of the start bit begins a run. When trigger mode is 1, a trigger pulse while the start bit is high begins a run. A start request during a run is ignored and does not reset the conversion count.
- R10: A low start bit during a run returns the block to idle one cycle later. The tags and stored values are kept, and while idle no word is accepted.
- R11: The raw overflow flag copies the flag of the stored word. The average overflow flag is the OR of the flags of all samples in that average.
- R12: When bit 5 and bit 6 are both set, the stored word is the bitwise complement of the input. On a differential channel (bit 5 = 0), the invert request has no effect.
- R13: The accumulator is cleared when the scan moves to another channel, so a partial sum never carries into the next channel's average.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_cfg_i | input | 80 | Five 16-bit channel setting words |
| scan_cont_i | input | 1 | 1 = continuous scan, 0 = single pass |
| hw_mode_i | input | 1 | 1 = event trigger start, 0 = start bit edge |
| start_bit_i | input | 1 | Start/stop control level |
| hw_trig_i | input | 1 | Event trigger pulse |
| smp_valid_i | input | 1 | Conversion word present |
| smp_data_i | input | 24 | Conversion word, two's complement |
| smp_ovf_i | input | 1 | Conversion word overflowed |
| smp_ready_o | output | 1 | Word accepted this cycle if valid |
| busy_o | output | 1 | Scan in progress |
| act_ch_o | output | 3 | Active multiplexer index |
| raw_data_o | output | 24 | Last stored conversion word |
| raw_ovf_o | output | 1 | Overflow flag of raw result |
| raw_tag_o | output | 3 | Channel tag of raw result |
| avg_data_o | output | 24 | Last published average |
| avg_ovf_o | output | 1 | Overflow flag of average |
| avg_tag_o | output | 3 | Channel tag of average |
| irq_o | output | 1 | One-cycle data interrupt |

## Verification
A wrong active-channel register shows up on the raw tag in the cycle right after the next accepted word. A wrong conversion counter first becomes visible when busy drops, or when the tag changes, one word too early or too late. Accumulator faults stay hidden until the end of an averaging window, so the depth sweep closes every window and compares the published value with a sum the bench computes itself. Stale accumulator state across a channel change shows up only in the next channel's first average.

// File: rtl/scan_avg_pkg.sv
package scan_avg_pkg;
  localparam int CNT_W   = 13;
  localparam int CNT_CAP = 8032;

  typedef struct packed {
    logic [7:0] cnt;
    logic       lin;
    logic       inv;
    logic       se;
    logic [1:0] depth;
    logic       irq_each;
    logic       avg_en;
    logic       en;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

  // Conversion count N for one channel
  function automatic logic [CNT_W-1:0] conv_target(input chan_cfg_t c);
    logic [CNT_W+7:0] wide;
    if (c.lin) begin
      if (c.cnt == 8'd0) return CNT_W'(1);
      return CNT_W'(c.cnt);
    end
    wide = ({{(CNT_W+3){1'b0}}, c.cnt[4:0]} + (CNT_W+8)'(1)) << c.cnt[7:5];
    if (wide > (CNT_W+8)'(CNT_CAP)) return CNT_W'(CNT_CAP);
    return wide[CNT_W-1:0];
  endfunction

  // Samples per average for a depth code
  function automatic logic [6:0] depth_count(input logic [1:0] code);
    return 7'(8) << code;
  endfunction
endpackage

// File: rtl/scan_chan_pick.sv
module scan_chan_pick #(
  parameter int NCH = 5,
  parameter int TW  = 3
) (
  input  logic [NCH-1:0] mask_i,
  input  logic [TW-1:0]  from_i,
  output logic           found_o,
  output logic [TW-1:0]  idx_o
);
  // Lowest enabled channel at or above from_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i] && (i >= int'(from_i))) begin
        found_o = 1'b1;
        idx_o   = TW'(i);
      end
    end
  end
endmodule

// File: rtl/scan_avg_acc.sv
module scan_avg_acc
  import scan_avg_pkg::*;
#(
  parameter int DW   = 24,
  parameter int ACCW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [DW-1:0] din_i,
  input  logic          ovf_i,
  input  logic [1:0]    depth_i,
  output logic          pub_o,
  output logic [DW-1:0] avg_o,
  output logic          avg_ovf_o
);
  logic [ACCW-1:0] sum_q, sum_nxt;
  logic [6:0]      cnt_q, cnt_nxt;
  logic            ovf_q;
  logic [2:0]      sh;

  assign sum_nxt   = sum_q + {{(ACCW-DW){din_i[DW-1]}}, din_i};
  assign cnt_nxt   = cnt_q + 7'd1;
  assign sh        = 3'd3 + {1'b0, depth_i};
  assign pub_o     = add_i && (cnt_nxt == depth_count(depth_i));
  assign avg_o     = DW'($signed(sum_nxt) >>> sh);
  assign avg_ovf_o = ovf_q | ovf_i;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i || pub_o) begin
      sum_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (add_i) begin
      sum_q <= sum_nxt;
      cnt_q <= cnt_nxt;
      ovf_q <= ovf_q | ovf_i;
    end
  end
endmodule

// File: rtl/scan_avg_seq.sv
module scan_avg_seq
  import scan_avg_pkg::*;
#(
  parameter int NCH  = 5,
  parameter int DW   = 24,
  parameter int ACCW = 31,
  parameter int TW   = $clog2(NCH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH*16-1:0]  ch_cfg_i,
  input  logic               scan_cont_i,
  input  logic               hw_mode_i,
  input  logic               start_bit_i,
  input  logic               hw_trig_i,
  input  logic               smp_valid_i,
  input  logic [DW-1:0]      smp_data_i,
  input  logic               smp_ovf_i,
  output logic               smp_ready_o,
  output logic               busy_o,
  output logic [TW-1:0]      act_ch_o,
  output logic [DW-1:0]      raw_data_o,
  output logic               raw_ovf_o,
  output logic [TW-1:0]      raw_tag_o,
  output logic [DW-1:0]      avg_data_o,
  output logic               avg_ovf_o,
  output logic [TW-1:0]      avg_tag_o,
  output logic               irq_o
);
  localparam int CW = CFG_W;

  function automatic logic [DW-1:0] shape(input logic [DW-1:0] d, input chan_cfg_t c);
    return (c.se && c.inv) ? ~d : d;
  endfunction

  chan_cfg_t      cfg [NCH];
  logic [NCH-1:0] en_mask;

  for (genvar g = 0; g < NCH; g++) begin : g_cfg
    assign cfg[g]     = ch_cfg_i[g*CW +: CW];
    assign en_mask[g] = cfg[g].en;
  end

  logic             busy_q, start_q, irq_q;
  logic [TW-1:0]    cur_q, nxt_from, next_idx, first_idx;
  logic [CNT_W-1:0] cnt_q, target;
  logic             next_found, first_found;
  chan_cfg_t        cur_cfg;

  // Named internal events
  logic sw_go, hw_go, start_go, smp_take, chan_done, stop_now;
  logic acc_clr, acc_add, avg_pub, avg_ovf_n, irq_d;
  logic [DW-1:0] shaped, avg_n;

  assign cur_cfg  = cfg[cur_q];
  assign nxt_from = cur_q + TW'(1);
  assign target   = conv_target(cur_cfg);

  scan_chan_pick #(.NCH(NCH), .TW(TW)) u_next (
    .mask_i (en_mask), .from_i(nxt_from), .found_o(next_found), .idx_o(next_idx)
  );
  scan_chan_pick #(.NCH(NCH), .TW(TW)) u_first (
    .mask_i (en_mask), .from_i('0), .found_o(first_found), .idx_o(first_idx)
  );

  assign sw_go     = !hw_mode_i && start_bit_i && !start_q;
  assign hw_go     = hw_mode_i && start_bit_i && hw_trig_i;
  assign start_go  = !busy_q && first_found && (sw_go || hw_go);
  assign smp_take  = smp_valid_i && busy_q;
  assign chan_done = smp_take && ((cnt_q + CNT_W'(1)) == target);
  assign stop_now  = busy_q && !start_bit_i;
  assign shaped    = shape(smp_data_i, cur_cfg);
  assign acc_clr   = start_go || chan_done || stop_now;
  assign acc_add   = smp_take && cur_cfg.avg_en;
  assign irq_d     = smp_take && (!cur_cfg.avg_en || cur_cfg.irq_each || avg_pub);

  scan_avg_acc #(.DW(DW), .ACCW(ACCW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (acc_clr),
    .add_i    (acc_add),
    .din_i    (shaped),
    .ovf_i    (smp_ovf_i),
    .depth_i  (cur_cfg.depth),
    .pub_o    (avg_pub),
    .avg_o    (avg_n),
    .avg_ovf_o(avg_ovf_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      start_q    <= 1'b0;
      irq_q      <= 1'b0;
      cur_q      <= '0;
      cnt_q      <= '0;
      raw_data_o <= '0;
      raw_ovf_o  <= 1'b0;
      raw_tag_o  <= '0;
      avg_data_o <= '0;
      avg_ovf_o  <= 1'b0;
      avg_tag_o  <= '0;
    end else begin
      start_q <= start_bit_i;
      irq_q   <= irq_d;
      if (start_go) begin
        busy_q <= 1'b1;
        cur_q  <= first_idx;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (smp_take) begin
          raw_data_o <= shaped;
          raw_ovf_o  <= smp_ovf_i;
          raw_tag_o  <= cur_q + TW'(1);
          if (chan_done) begin
            cnt_q <= '0;
            if (next_found)       cur_q  <= next_idx;
            else if (scan_cont_i) cur_q  <= first_idx;
            else                  busy_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        if (avg_pub) begin
          avg_data_o <= avg_n;
          avg_ovf_o  <= avg_ovf_n;
          avg_tag_o  <= cur_q + TW'(1);
        end
        if (stop_now) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end
      end
    end
  end

  assign smp_ready_o = busy_q;
  assign busy_o      = busy_q;
  assign act_ch_o    = cur_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/scan_avg_seq_chk.sv
module scan_avg_seq_chk #(
  parameter int NCH = 5,
  parameter int DW  = 24,
  parameter int TW  = $clog2(NCH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_take,
  input logic          avg_pub,
  input logic          irq_o,
  input logic          busy_o,
  input logic          start_bit_i,
  input logic [TW-1:0] act_ch_o,
  input logic [TW-1:0] raw_tag_o,
  input logic [TW-1:0] avg_tag_o,
  input logic [DW-1:0] avg_data_o
);
  a_r1_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(raw_tag_o) <= NCH) && (int'(avg_tag_o) <= NCH));

  a_r2_tag_from_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_take) |-> (raw_tag_o == TW'($past(act_ch_o) + TW'(1))));

  a_r3_irq_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(smp_take));

  a_r4_avg_only_on_publish: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(avg_pub) |-> ($stable(avg_data_o) && $stable(avg_tag_o)));

  a_r9_run_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_bit_i));

  a_r10_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_take) |-> $stable(raw_tag_o));
endmodule

bind scan_avg_seq scan_avg_seq_chk #(.NCH(NCH), .DW(DW), .TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_take   (smp_take),
  .avg_pub    (avg_pub),
  .irq_o      (irq_o),
  .busy_o     (busy_o),
  .start_bit_i(start_bit_i),
  .act_ch_o   (act_ch_o),
  .raw_tag_o  (raw_tag_o),
  .avg_tag_o  (avg_tag_o),
  .avg_data_o (avg_data_o)
);

// File: tb/scan_avg_seq_test.sv
module scan_avg_seq_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfgv [5];
  logic [79:0] ch_cfg;
  logic        scan_cont = 1'b0, hw_mode = 1'b0, start_bit = 1'b0, hw_trig = 1'b0;
  logic        smp_valid = 1'b0, smp_ovf = 1'b0;
  logic [23:0] smp_data = '0;
  logic        smp_ready, busy, raw_ovf, avg_ovf, irq;
  logic [2:0]  act_ch, raw_tag, avg_tag;
  logic [23:0] raw_data, avg_data;
  int          checks = 0, fails = 0, irqs = 0;

  always #(PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < 5; i++) ch_cfg[i*16 +: 16] = cfgv[i];

  scan_avg_seq uut (
    .clk(clk), .rst_n(rst_n), .ch_cfg_i(ch_cfg), .scan_cont_i(scan_cont),
    .hw_mode_i(hw_mode), .start_bit_i(start_bit), .hw_trig_i(hw_trig),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data), .smp_ovf_i(smp_ovf),
    .smp_ready_o(smp_ready), .busy_o(busy), .act_ch_o(act_ch),
    .raw_data_o(raw_data), .raw_ovf_o(raw_ovf), .raw_tag_o(raw_tag),
    .avg_data_o(avg_data), .avg_ovf_o(avg_ovf), .avg_tag_o(avg_tag), .irq_o(irq)
  );

  always @(negedge clk) if (rst_n && irq) irqs++;

  function automatic logic [15:0] mk(input logic en, input logic av, input logic each,
                                     input logic [1:0] dep, input logic se, input logic inv,
                                     input logic lin, input logic [7:0] cnt);
    return {cnt, lin, inv, se, dep, each, av, en};
  endfunction

  function automatic logic [23:0] avg_of(input longint s, input int k);
    longint q;
    q = s >>> k;
    return q[23:0];
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] d, input logic o);
    @(negedge clk); smp_valid = 1'b1; smp_data = d; smp_ovf = o;
    @(negedge clk); smp_valid = 1'b0; smp_ovf = 1'b0;
  endtask

  task automatic sw_start();
    start_bit = 1'b0; @(negedge clk);
    start_bit = 1'b1; @(negedge clk);
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < 5; i++) cfgv[i] = '0;
  endtask

  initial begin
    #(PERIOD*150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, fails);
    $finish;
  end

  initial begin
    clear_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 ready", smp_ready, 0);
    chk("R1 irq", irq, 0);
    chk("R1 raw tag", raw_tag, 0);
    chk("R1 avg tag", avg_tag, 0);

    // R7 no channel enabled: no start
    sw_start();
    repeat (2) @(negedge clk);
    chk("R7 idle with no channel", busy, 0);

    // R2 R3 R7 R8: ch0 N=3, ch1 off, ch2 N=2, averaging off, single pass
    cfgv[0] = mk(1, 0, 0, 0, 0, 0, 1, 3);
    cfgv[2] = mk(1, 0, 0, 0, 0, 0, 1, 2);
    sw_start();
    chk("R9 sw start", busy, 1);
    chk("R7 first channel", act_ch, 0);
    for (int i = 0; i < 5; i++) begin
      send(24'h100000 + 24'(i), 1'b0);
      chk("R3 raw value", raw_data, 24'h100000 + i);
      chk("R2 tag", raw_tag, (i < 3) ? 1 : 3);
      chk("R3 irq each", irq, 1);
      if (i == 2) chk("R7 skip disabled", act_ch, 2);
    end
    chk("R8 single pass ends", busy, 0);
    chk("R3 avg untouched", avg_tag, 0);

    // R4 R5 depth sweep on ch1, per-average interrupt
    for (int code = 0; code < 4; code++) begin
      int     dep;
      int     base;
      longint sum;
      dep = 8 << code;
      sum = 0;
      clear_cfg();
      cfgv[1] = mk(1, 1, 0, 2'(code), 0, 0, 1, 8'(dep));
      sw_start();
      @(negedge clk);
      base = irqs;
      for (int i = 0; i < dep; i++) begin
        longint s;
        s = longint'(i) * 9973 - 250000 + code * 31;
        sum += s;
        send(s[23:0], 1'b0);
      end
      chk("R4 avg value", avg_data, avg_of(sum, 3 + code));
      chk("R4 avg tag", avg_tag, 2);
      chk("R5 irq at publish", irq, 1);
      chk("R8 end after N", busy, 0);
      @(negedge clk);
      chk("R5 one irq per average", irqs - base, 1);
    end

    // R5 per-conversion interrupt while averaging
    begin
      longint sum;
      int     base;
      sum = 0;
      clear_cfg();
      cfgv[0] = mk(1, 1, 1, 0, 0, 0, 1, 8);
      sw_start();
      base = irqs;
      for (int i = 0; i < 8; i++) begin
        sum += 1000 * i + 7;
        send(24'(1000 * i + 7), 1'b0);
      end
      @(negedge clk);
      chk("R5 irq every conversion", irqs - base, 8);
      chk("R4 avg per-conv mode", avg_data, avg_of(sum, 3));
      chk("R4 avg tag ch0", avg_tag, 1);
    end

    // R11 overflow flags
    clear_cfg();
    cfgv[0] = mk(1, 1, 0, 0, 0, 0, 1, 8);
    sw_start();
    for (int i = 0; i < 8; i++) begin
      send(24'(i), (i == 3));
      if (i == 3) chk("R11 raw ovf set", raw_ovf, 1);
      if (i == 4) chk("R11 raw ovf clear", raw_ovf, 0);
    end
    chk("R11 avg ovf OR", avg_ovf, 1);

    // R12 inversion
    clear_cfg();
    cfgv[0] = mk(1, 0, 0, 0, 1, 1, 1, 2);
    cfgv[1] = mk(1, 0, 0, 0, 0, 1, 1, 1);
    sw_start();
    send(24'h123456, 1'b0);
    chk("R12 single-ended inverted", raw_data, 24'hEDCBA9);
    send(24'h0000FF, 1'b0);
    chk("R12 single-ended inverted 2", raw_data, 24'hFFFF00);
    send(24'h123456, 1'b0);
    chk("R12 differential unchanged", raw_data, 24'h123456);
    chk("R12 tag", raw_tag, 2);

    // R6 exponential count m=2 n=1 -> 6, linear 0 -> 1
    clear_cfg();
    cfgv[3] = mk(1, 0, 0, 0, 0, 0, 0, {3'd1, 5'd2});
    cfgv[4] = mk(1, 0, 0, 0, 0, 0, 1, 8'd0);
    sw_start();
    for (int i = 0; i < 6; i++) begin
      send(24'(i), 1'b0);
      if (i == 4) chk("R6 exp count not reached", act_ch, 3);
    end
    chk("R6 exp count reached", act_ch, 4);
    chk("R6 still busy", busy, 1);
    send(24'h55, 1'b0);
    chk("R6 linear zero counts one", busy, 0);
    chk("R6 tag", raw_tag, 5);

    // R8 continuous wrap, R10 stop
    clear_cfg();
    cfgv[0] = mk(1, 0, 0, 0, 0, 0, 1, 1);
    cfgv[4] = mk(1, 0, 0, 0, 0, 0, 1, 1);
    scan_cont = 1'b1;
    sw_start();
    for (int i = 0; i < 5; i++) begin
      send(24'(i + 40), 1'b0);
      chk("R8 wrap tag", raw_tag, (i % 2 == 0) ? 1 : 5);
    end
    chk("R8 continuous busy", busy, 1);
    start_bit = 1'b0;
    @(negedge clk);
    chk("R10 stop idle", busy, 0);
    chk("R10 ready low", smp_ready, 0);
    send(24'hABCDEF, 1'b0);
    chk("R10 idle ignores word", raw_data, 44);
    chk("R10 tag kept", raw_tag, 1);
    chk("R10 no irq", irq, 0);
    scan_cont = 1'b0;

    // R9 hardware trigger, start during run ignored
    clear_cfg();
    cfgv[2] = mk(1, 0, 0, 0, 0, 0, 1, 4);
    hw_mode = 1'b1;
    start_bit = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 no trigger no run", busy, 0);
    hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    chk("R9 trigger starts", busy, 1);
    send(24'd1, 1'b0);
    send(24'd2, 1'b0);
    hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    send(24'd3, 1'b0);
    chk("R9 still running", busy, 1);
    send(24'd4, 1'b0);
    chk("R9 restart ignored", busy, 0);
    hw_mode = 1'b0;
    start_bit = 1'b0;

    // R13 accumulator cleared at channel switch
    clear_cfg();
    cfgv[0] = mk(1, 1, 0, 0, 0, 0, 1, 4);
    cfgv[1] = mk(1, 1, 0, 0, 0, 0, 1, 8);
    sw_start();
    for (int i = 0; i < 4; i++) send(24'd1000000, 1'b0);
    chk("R13 partial not published", avg_data, avg_of(longint'(28), 3));
    for (int i = 0; i < 8; i++) send(24'(i * 10), 1'b0);
    chk("R13 clean average", avg_data, 35);
    chk("R13 tag", avg_tag, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, fails);
    $finish;
  end
endmodule